// File: doc/BRIEF.md
# Epoch Hill-Climbing Partition Controller

This block decides how many allocation units of a shared cache each of two cores may use, and revises that split once per epoch. It never needs a dedicated utility monitor: it simply tries the neighbouring splits for one epoch each, compares the policy metric measured during each trial, and settles on whichever configuration scored best. The split lives in `core0_units` and `core1_units`, which always hold the allocation to enforce during the epoch that is starting.

A decision round spans up to three epochs. The first runs at the current split, the second at one step fewer units for core 0, and the third at one step more units for core 0. When the last trial ends, the winning split becomes the new current split and the next round begins. A trial that would drop either core below the minimum is skipped entirely, which shortens the round. The metric can be a quantity where larger is better, such as summed IPC, or one where smaller is better, such as combined misses. A mode input chooses which.

An external epoch timer raises `epoch_end` for one cycle at each epoch boundary. In that same cycle it presents the metric for the epoch that just finished, qualified by `metric_valid`.

Top module: `hcp_partition_ctrl`

## Requirements
- R1: During and after reset, `core0_units` and `core1_units` both equal TOTAL_UNITS/2. The default TOTAL_UNITS is 16, so both read 8.
- R2: Starting from current split p:(16-p), the `epoch_end` of the current-split epoch sets `core0_units` to p-1, and the next one sets it to p+1. In every case a split is skipped if it would break R5. Outputs update at the clock edge that samples `epoch_end`.
- R3: The `epoch_end` that closes the last trial of a round sets the outputs to the best of the three configurations. With `higher_better`=1 the larger unsigned metric wins; with 0 the smaller one wins. The mode is sampled at that deciding edge.
- R4: On equal metrics the current split is kept, and the lower-unit neighbour (p-1) beats the upper one (p+1).
- R5: `core0_units + core1_units` always equals 16, and neither output is ever below MIN_UNITS = 2. Legal splits therefore run from 2:14 to 14:2.
- R6: A neighbour that would break R5 gets no trial epoch. At 2:14 a round is current then p+1; at 14:2 it is current then p-1. The skipped slot never wins.
- R7: An `epoch_end` with `metric_valid`=0 still advances the round, but that slot counts as a loss. If all slots of a round lose, the current split is kept.
- R8: The outputs change only on a cycle where `epoch_end` is high. A `metric_valid` or `metric` change without `epoch_end` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| epoch_end | input | 1 | One-cycle pulse marking the end of an epoch |
| metric_valid | input | 1 | Qualifies `metric` in the `epoch_end` cycle |
| metric | input | METRIC_W (32) | Policy metric of the epoch just ended, unsigned |
| higher_better | input | 1 | 1: larger metric wins, 0: smaller metric wins |
| core0_units | output | UW (5) | Units granted to core 0 for the coming epoch |
| core1_units | output | UW (5) | Units granted to core 1 for the coming epoch |

## Verification
The assertions check, on every cycle, the invariants of the split. The two counts always sum to the total and never fall below the minimum. The split holds still between `epoch_end` pulses. No single pulse moves core 0 by more than two steps. Reset restores the even split. Which configuration wins a round, the order of trial epochs, tie priority, treatment of unqualified samples and the shortened rounds at both bounds can only be shown by the bench's directed rounds. Those rounds feed chosen metric sequences and compare the outputs after each pulse against an independent model of the round.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  typedef enum logic [1:0] {
    PH_CUR = 2'd0,
    PH_LO  = 2'd1,
    PH_HI  = 2'd2
  } phase_t;

  localparam int NUM_SLOTS = 3;

  // Strict preference of candidate a over incumbent b under the given mode.
  function automatic logic metric_beats(input logic [63:0] a,
                                        input logic [63:0] b,
                                        input logic        hi_wins);
    if (hi_wins) return a > b;
    else         return a < b;
  endfunction

endpackage

// File: rtl/hcp_split_bounds.sv
module hcp_split_bounds #(
  parameter int TOTAL_UNITS = 16,
  parameter int MIN_UNITS   = 2,
  parameter int STEP        = 1,
  parameter int UW          = $clog2(TOTAL_UNITS + 1)
) (
  input  logic [UW-1:0] base_p0,
  output logic          lo_ok,
  output logic          hi_ok,
  output logic [UW-1:0] lo_p0,
  output logic [UW-1:0] hi_p0
);

  localparam int LO_FLOOR = MIN_UNITS + STEP;
  localparam int HI_CEIL  = TOTAL_UNITS - MIN_UNITS - STEP;

  always_comb begin
    lo_ok = (int'(base_p0) >= LO_FLOOR);
    hi_ok = (int'(base_p0) <= HI_CEIL);
    lo_p0 = base_p0 - UW'(STEP);
    hi_p0 = base_p0 + UW'(STEP);
  end

endmodule

// File: rtl/hcp_slot_store.sv
module hcp_slot_store #(
  parameter int METRIC_W = 32,
  parameter int NSLOT    = 3,
  parameter int IW       = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clear,
  input  logic                            wr_en,
  input  logic [IW-1:0]                   wr_idx,
  input  logic [METRIC_W-1:0]             wr_data,
  input  logic                            wr_vld,
  output logic [NSLOT-1:0][METRIC_W-1:0]  slot_data,
  output logic [NSLOT-1:0]                slot_vld
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        slot_vld[g] <= 1'b0;
      end else if (wr_en && (int'(wr_idx) == g)) begin
        slot_vld[g] <= wr_vld;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (int'(wr_idx) == g)) begin
        slot_data[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/hcp_winner.sv
module hcp_winner
  import hcp_pkg::*;
#(
  parameter int METRIC_W = 32
) (
  input  logic [NUM_SLOTS-1:0][METRIC_W-1:0] cand_data,
  input  logic [NUM_SLOTS-1:0]               cand_vld,
  input  logic                               hi_wins,
  output phase_t                             win,
  output logic                               any_vld
);

  logic [63:0] best_val;
  logic        best_ok;

  // Slots are visited in priority order cur, lo, hi; only a strict
  // improvement displaces the incumbent, which yields the tie rules.
  always_comb begin
    win      = PH_CUR;
    best_val = 64'(cand_data[0]);
    best_ok  = cand_vld[0];
    for (int i = 1; i < NUM_SLOTS; i++) begin
      if (cand_vld[i] &&
          (!best_ok || metric_beats(64'(cand_data[i]), best_val, hi_wins))) begin
        win      = phase_t'(i);
        best_val = 64'(cand_data[i]);
        best_ok  = 1'b1;
      end
    end
    any_vld = best_ok;
  end

endmodule

// File: rtl/hcp_partition_ctrl.sv
module hcp_partition_ctrl
  import hcp_pkg::*;
#(
  parameter int TOTAL_UNITS = 16,
  parameter int MIN_UNITS   = 2,
  parameter int STEP        = 1,
  parameter int METRIC_W    = 32,
  parameter int UW          = $clog2(TOTAL_UNITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                epoch_end,
  input  logic                metric_valid,
  input  logic [METRIC_W-1:0] metric,
  input  logic                higher_better,
  output logic [UW-1:0]       core0_units,
  output logic [UW-1:0]       core1_units
);

  localparam logic [UW-1:0] HALF  = UW'(TOTAL_UNITS / 2);
  localparam logic [UW-1:0] TOTAL = UW'(TOTAL_UNITS);

  phase_t         phase;
  logic [UW-1:0]  base_p0;
  logic           lo_ok, hi_ok;
  logic [UW-1:0]  lo_p0, hi_p0;

  logic [NUM_SLOTS-1:0][METRIC_W-1:0] st_data, eff_data;
  logic [NUM_SLOTS-1:0]               st_vld, eff_vld;
  phase_t                             win;
  logic                               any_vld;

  logic           decide;
  logic [UW-1:0]  win_p0;
  phase_t         nxt_phase;
  logic [UW-1:0]  nxt_out;

  hcp_split_bounds #(
    .TOTAL_UNITS (TOTAL_UNITS),
    .MIN_UNITS   (MIN_UNITS),
    .STEP        (STEP),
    .UW          (UW)
  ) u_bounds (
    .base_p0 (base_p0),
    .lo_ok   (lo_ok),
    .hi_ok   (hi_ok),
    .lo_p0   (lo_p0),
    .hi_p0   (hi_p0)
  );

  hcp_slot_store #(
    .METRIC_W (METRIC_W),
    .NSLOT    (NUM_SLOTS),
    .IW       (2)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .clear     (decide),
    .wr_en     (epoch_end && !decide),
    .wr_idx    (phase),
    .wr_data   (metric),
    .wr_vld    (metric_valid),
    .slot_data (st_data),
    .slot_vld  (st_vld)
  );

  // The slot of the epoch ending now is taken straight from the inputs.
  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (int'(phase) == i) begin
        eff_data[i] = metric;
        eff_vld[i]  = metric_valid;
      end else begin
        eff_data[i] = st_data[i];
        eff_vld[i]  = st_vld[i];
      end
    end
  end

  hcp_winner #(
    .METRIC_W (METRIC_W)
  ) u_winner (
    .cand_data (eff_data),
    .cand_vld  (eff_vld),
    .hi_wins   (higher_better),
    .win       (win),
    .any_vld   (any_vld)
  );

  always_comb begin
    case (win)
      PH_LO:   win_p0 = lo_p0;
      PH_HI:   win_p0 = hi_p0;
      default: win_p0 = base_p0;
    endcase
    if (!any_vld) win_p0 = base_p0;
  end

  // Round sequencing: pick the next trial or close the round.
  always_comb begin
    decide    = 1'b0;
    nxt_phase = PH_CUR;
    nxt_out   = base_p0;
    case (phase)
      PH_CUR: begin
        if (lo_ok) begin
          nxt_phase = PH_LO;
          nxt_out   = lo_p0;
        end else if (hi_ok) begin
          nxt_phase = PH_HI;
          nxt_out   = hi_p0;
        end else begin
          decide = epoch_end;
        end
      end
      PH_LO: begin
        if (hi_ok) begin
          nxt_phase = PH_HI;
          nxt_out   = hi_p0;
        end else begin
          decide = epoch_end;
        end
      end
      default: decide = epoch_end;
    endcase
    if (decide) begin
      nxt_phase = PH_CUR;
      nxt_out   = win_p0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_CUR;
      base_p0     <= HALF;
      core0_units <= HALF;
      core1_units <= TOTAL - HALF;
    end else if (epoch_end) begin
      phase       <= nxt_phase;
      core0_units <= nxt_out;
      core1_units <= TOTAL - nxt_out;
      if (decide) base_p0 <= win_p0;
    end
  end

endmodule

// File: rtl/hcp_checker.sv
module hcp_checker #(
  parameter int TOTAL_UNITS = 16,
  parameter int MIN_UNITS   = 2,
  parameter int STEP        = 1,
  parameter int UW          = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          epoch_end,
  input logic [UW-1:0] core0_units,
  input logic [UW-1:0] core1_units
);

  p_reset_even_r1: assert property (@(posedge clk)
    rst |=> (int'(core0_units) == TOTAL_UNITS / 2));

  p_sum_total_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(core0_units) + int'(core1_units)) == TOTAL_UNITS);

  p_min_units_r5: assert property (@(posedge clk) disable iff (rst)
    (int'(core0_units) >= MIN_UNITS) && (int'(core1_units) >= MIN_UNITS));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !epoch_end |=> $stable(core0_units));

  p_step_bound_r2: assert property (@(posedge clk) disable iff (rst)
    epoch_end |=> ((int'(core0_units) <= int'($past(core0_units)) + 2 * STEP) &&
                   (int'(core0_units) + 2 * STEP >= int'($past(core0_units)))));

endmodule

bind hcp_partition_ctrl hcp_checker #(
  .TOTAL_UNITS (TOTAL_UNITS),
  .MIN_UNITS   (MIN_UNITS),
  .STEP        (STEP),
  .UW          (UW)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .epoch_end   (epoch_end),
  .core0_units (core0_units),
  .core1_units (core1_units)
);

// File: tb/hcp_partition_ctrl_bench.sv
module hcp_partition_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TOTAL      = 16;
  localparam int MINU       = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        epoch_end;
  logic        metric_valid;
  logic [31:0] metric;
  logic        higher_better;
  logic [4:0]  core0_units, core1_units;

  int total_checks = 0;
  int bad_checks   = 0;
  int exp_p0       = 8;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hcp_partition_ctrl u_hcp_partition_ctrl (
    .clk           (clk),
    .rst           (rst),
    .epoch_end     (epoch_end),
    .metric_valid  (metric_valid),
    .metric        (metric),
    .higher_better (higher_better),
    .core0_units   (core0_units),
    .core1_units   (core1_units)
  );

  task automatic check_split(input int exp0, input string tag);
    total_checks++;
    if (int'(core0_units) != exp0 || int'(core1_units) != TOTAL - exp0) begin
      bad_checks++;
      $display("FAIL %s: got %0d:%0d expected %0d:%0d", tag,
               core0_units, core1_units, exp0, TOTAL - exp0);
    end
  endtask

  task automatic pulse(input int m, input bit v);
    @(negedge clk);
    epoch_end    = 1'b1;
    metric       = 32'(m);
    metric_valid = v;
    @(negedge clk);
    epoch_end    = 1'b0;
    metric_valid = 1'b0;
  endtask

  function automatic bit prefers(input int a, input int b, input bit hib);
    return hib ? (a > b) : (a < b);
  endfunction

  // One full round against an independent model of the rules.
  task automatic run_round(input int c, input int l, input int h,
                           input bit cv, input bit lv, input bit hv,
                           input bit hib, input string tag);
    int p = exp_p0;
    bit lo_ok = (p - 1 >= MINU);
    bit hi_ok = (p + 1 <= TOTAL - MINU);
    int best_p = p;
    int best_m = c;
    bit best_v = cv;
    higher_better = hib;
    if (lo_ok && lv && (!best_v || prefers(l, best_m, hib))) begin
      best_p = p - 1; best_m = l; best_v = 1'b1;
    end
    if (hi_ok && hv && (!best_v || prefers(h, best_m, hib))) begin
      best_p = p + 1; best_m = h; best_v = 1'b1;
    end
    pulse(c, cv);
    if (lo_ok) begin
      check_split(p - 1, {tag, " R2 lower trial"});
      pulse(l, lv);
      if (hi_ok) begin
        check_split(p + 1, {tag, " R2 upper trial"});
        pulse(h, hv);
      end
    end else if (hi_ok) begin
      check_split(p + 1, {tag, " R6 upper trial after skip"});
      pulse(h, hv);
    end
    check_split(best_p, {tag, " R3 decision"});
    exp_p0 = best_p;
  endtask

  task automatic t_reset();
    rst = 1'b1; epoch_end = 1'b0; metric_valid = 1'b0; metric = '0;
    higher_better = 1'b1;
    repeat (3) @(negedge clk);
    check_split(8, "R1 during reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_split(8, "R1 after reset");
    exp_p0 = 8;
  endtask

  task automatic t_modes();
    run_round(10, 20, 5, 1, 1, 1, 1'b1, "R3 higher wins");
    check_split(7, "R3 higher picks lower neighbour");
    run_round(10, 20, 5, 1, 1, 1, 1'b0, "R3 lower wins");
    check_split(8, "R3 lower picks upper neighbour");
  endtask

  task automatic t_ties();
    run_round(50, 50, 50, 1, 1, 1, 1'b1, "R4 all equal");
    check_split(8, "R4 current kept on tie");
    run_round(50, 60, 60, 1, 1, 1, 1'b1, "R4 neighbours equal");
    check_split(7, "R4 lower neighbour beats upper");
  endtask

  task automatic t_invalid();
    run_round(100, 999, 50, 1, 0, 1, 1'b1, "R7 unqualified lower");
    check_split(7, "R7 unqualified slot loses");
    run_round(1, 2, 3, 0, 0, 0, 1'b1, "R7 none qualified");
    check_split(7, "R7 all lost keeps current");
    run_round(900, 1, 0, 0, 1, 1, 1'b1, "R7 current unqualified");
    check_split(6, "R7 qualified neighbour wins");
  endtask

  task automatic t_ignore();
    @(negedge clk);
    metric_valid = 1'b1; metric = 32'hFFFF_FFFF;
    repeat (5) @(negedge clk);
    check_split(6, "R8 sample without epoch_end ignored");
    metric_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_split(6, "R8 idle cycles hold split");
    run_round(5, 4, 3, 1, 1, 1, 1'b1, "R8 round after stray sample");
    check_split(6, "R8 stray sample not counted");
  endtask

  task automatic t_low_bound();
    for (int k = 0; k < 4; k++) run_round(1, 9, 0, 1, 1, 1, 1'b1, "R2 walk down");
    check_split(2, "R5 reached lowest legal split");
    run_round(10, 0, 5, 1, 1, 1, 1'b1, "R6 floor round");
    check_split(2, "R6 floor keeps current");
    run_round(10, 99, 20, 1, 1, 1, 1'b1, "R6 floor upper wins");
    check_split(3, "R6 floor moves up");
  endtask

  task automatic t_high_bound();
    for (int k = 0; k < 11; k++) run_round(1, 0, 9, 1, 1, 1, 1'b1, "R2 walk up");
    check_split(14, "R5 reached highest legal split");
    run_round(10, 99, 0, 1, 1, 1, 1'b0, "R6 ceiling round");
    check_split(14, "R6 ceiling keeps current");
    run_round(10, 3, 0, 1, 1, 1, 1'b0, "R6 ceiling lower wins");
    check_split(13, "R6 ceiling moves down");
  endtask

  initial begin
    t_reset();
    t_modes();
    t_ties();
    t_invalid();
    t_ignore();
    t_low_bound();
    t_high_bound();
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total_checks++;
    bad_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end

endmodule